// File: doc/BRIEF.md
# Ethernet MAC interrupt vector unit

This unit gathers the interrupt events of an eight-channel Ethernet MAC into one readable status word and a single interrupt line toward the host processor. The events are transmit-done and receive-done pulses, each carrying a channel index, plus a host-error pulse and a status-change pulse. Each event sets a sticky pending bit. A pending bit is reported only when its mask bit is enabled. The transmit and receive groups each have an eight-bit mask. Host-error and status events share a two-bit mask.

Software programs the masks through write-one-to-set and write-one-to-clear strobes. It reads the vector word to learn which class is active and the lowest active channel of each direction. It clears each serviced source with an acknowledge write. Finally it writes an end-of-interrupt command, which drops the line and lets it re-assert later if anything remains active. All software accesses use one write port: a 4-bit command code and an 8-bit data word.

Top module: `mac_irq_vector`

## Requirements
- R1: After reset all pending bits and all masks are zero, `vector_o` reads 0 and `irq_o` is low.
- R2: A transmit pulse on channel c sets transmit pending bit c whatever the mask. Vector bit 16 reads 1 one clock later only if that channel's transmit mask bit is set.
- R3: A receive pulse on channel c sets receive pending bit c whatever the mask. Vector bit 17 reads 1 one clock later only if that channel's receive mask bit is set.
- R4: Vector bits 2:0 hold the lowest-numbered channel that is both pending and enabled for transmit. Vector bits 10:8 hold the same for receive. Each field reads 0 when its group has no such channel.
- R5: Command 0 sets and command 1 clears transmit mask bits wherever the data has ones. Commands 2 and 3 do the same for the receive mask. Zero data bits leave mask bits unchanged.
- R6: Host-error pending is reported in vector bit 18 when mask bit 0 is set. Status pending is reported in bit 19 when mask bit 1 is set. Command 4 sets and command 5 clears these mask bits. Command 8 clears host pending when data bit 0 is 1 and status pending when data bit 1 is 1.
- R7: Command 6 (transmit) and command 7 (receive) clear the pending bit of the channel given in data bits 2:0. If an event on the same channel arrives in the same cycle, the pending bit stays set.
- R8: `irq_o` rises one clock after any vector flag (bits 19:16) becomes 1. Once high, it stays high until an end-of-interrupt command, even if every flag clears.
- R9: Command 9 is end-of-interrupt. After it, `irq_o` is low for the next two clocks, then rises again if any vector flag is 1. End-of-interrupt wins over a new event in the same cycle.
- R10: Commands 10 to 15 change no mask and no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done_i | input | 1 | One-cycle transmit-complete pulse |
| tx_chan_i | input | 3 | Channel of the transmit pulse |
| rx_done_i | input | 1 | One-cycle receive-complete pulse |
| rx_chan_i | input | 3 | Channel of the receive pulse |
| host_err_i | input | 1 | One-cycle host-error pulse |
| stat_chg_i | input | 1 | One-cycle status-change pulse |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_code_i | input | 4 | Command code |
| cmd_data_i | input | 8 | Command data |
| vector_o | output | 32 | Interrupt vector word |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
Two functions can land in the same cycle. The first case is a channel acknowledge and a fresh event on that same channel. The second is an end-of-interrupt write and a new source event. Directed steps drive each pair on one clock edge. They confirm that the pending bit survives the acknowledge and that the line still keeps its two-clock low gap before rising for the new event. A random phase then mixes events, mask commands, acknowledges and end-of-interrupt writes freely. A behavioural model checks the vector word and the line on every clock.

// File: rtl/mac_irq_vector.sv
module mac_irq_vector #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_done_i,
  input  logic [CHW-1:0] tx_chan_i,
  input  logic           rx_done_i,
  input  logic [CHW-1:0] rx_chan_i,
  input  logic           host_err_i,
  input  logic           stat_chg_i,
  input  logic           cmd_we_i,
  input  logic [3:0]     cmd_code_i,
  input  logic [NCH-1:0] cmd_data_i,
  output logic [31:0]    vector_o,
  output logic           irq_o
);

  localparam logic [3:0] C_TXSET = 4'd0, C_TXCLR = 4'd1, C_RXSET = 4'd2, C_RXCLR = 4'd3;
  localparam logic [3:0] C_MSET  = 4'd4, C_MCLR  = 4'd5, C_TXACK = 4'd6, C_RXACK = 4'd7;
  localparam logic [3:0] C_MACK  = 4'd8, C_EOI   = 4'd9;

  logic [NCH-1:0] tx_pend, rx_pend, tx_en, rx_en;
  logic           host_pend, stat_pend;
  logic [1:0]     mac_en;
  logic           irq_q, gap_q;

  function automatic logic [CHW-1:0] lowest(input logic [NCH-1:0] v);
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) lowest = CHW'(i);
  endfunction

  function automatic logic [NCH-1:0] onehot(input logic [CHW-1:0] ch);
    onehot = NCH'(1) << ch;
  endfunction

  wire hit_txack = cmd_we_i && cmd_code_i == C_TXACK;
  wire hit_rxack = cmd_we_i && cmd_code_i == C_RXACK;
  wire hit_mack  = cmd_we_i && cmd_code_i == C_MACK;
  wire hit_eoi   = cmd_we_i && cmd_code_i == C_EOI;

  wire [NCH-1:0] tx_set = tx_done_i ? onehot(tx_chan_i) : '0;
  wire [NCH-1:0] rx_set = rx_done_i ? onehot(rx_chan_i) : '0;
  wire [NCH-1:0] tx_clr = hit_txack ? onehot(cmd_data_i[CHW-1:0]) : '0;
  wire [NCH-1:0] rx_clr = hit_rxack ? onehot(cmd_data_i[CHW-1:0]) : '0;

  wire [NCH-1:0] tx_act = tx_pend & tx_en;
  wire [NCH-1:0] rx_act = rx_pend & rx_en;
  wire           f_tx   = |tx_act;
  wire           f_rx   = |rx_act;
  wire           f_host = host_pend & mac_en[0];
  wire           f_stat = stat_pend & mac_en[1];
  wire           any_f  = f_tx | f_rx | f_host | f_stat;

  assign vector_o = {12'b0, f_stat, f_host, f_rx, f_tx,
                     5'b0, 3'(lowest(rx_act)), 5'b0, 3'(lowest(tx_act))};
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_pend   <= '0;
      rx_pend   <= '0;
      host_pend <= 1'b0;
      stat_pend <= 1'b0;
    end else begin
      tx_pend   <= (tx_pend & ~tx_clr) | tx_set;
      rx_pend   <= (rx_pend & ~rx_clr) | rx_set;
      host_pend <= (host_pend & ~(hit_mack & cmd_data_i[0])) | host_err_i;
      stat_pend <= (stat_pend & ~(hit_mack & cmd_data_i[1])) | stat_chg_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en  <= '0;
      rx_en  <= '0;
      mac_en <= '0;
    end else if (cmd_we_i) begin
      case (cmd_code_i)
        C_TXSET: tx_en  <= tx_en | cmd_data_i;
        C_TXCLR: tx_en  <= tx_en & ~cmd_data_i;
        C_RXSET: rx_en  <= rx_en | cmd_data_i;
        C_RXCLR: rx_en  <= rx_en & ~cmd_data_i;
        C_MSET:  mac_en <= mac_en | cmd_data_i[1:0];
        C_MCLR:  mac_en <= mac_en & ~cmd_data_i[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      gap_q <= hit_eoi;
      if (hit_eoi)
        irq_q <= 1'b0;
      else if (!gap_q && any_f)
        irq_q <= 1'b1;
    end
  end

  AST_EOI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_eoi |=> !irq_o ##1 !irq_o); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !hit_eoi) |=> irq_o); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|vector_o[19:16])); // R8
  AST_TX_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_i && tx_en[tx_chan_i] && !(cmd_we_i && cmd_code_i == C_TXCLR)) |=> vector_o[16]); // R2
  AST_RX_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_en[rx_chan_i] && !(cmd_we_i && cmd_code_i == C_RXCLR)) |=> vector_o[17]); // R3

endmodule

// File: tb/test_mac_irq_vector.sv
module test_mac_irq_vector;
  logic clk = 0, rst_n = 0;
  logic tx_done = 0, rx_done = 0, host_err = 0, stat_chg = 0, we = 0;
  logic [2:0] tx_chan = 0, rx_chan = 0;
  logic [3:0] code = 0;
  logic [7:0] data = 0;
  logic [31:0] vec;
  logic irq;
  int checks = 0, errors = 0, cyc_n = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  mac_irq_vector i_mac_irq_vector (
    .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done), .tx_chan_i(tx_chan),
    .rx_done_i(rx_done), .rx_chan_i(rx_chan), .host_err_i(host_err),
    .stat_chg_i(stat_chg), .cmd_we_i(we), .cmd_code_i(code),
    .cmd_data_i(data), .vector_o(vec), .irq_o(irq));

  bit [7:0] m_txp, m_rxp, m_txm, m_rxm;
  bit m_hp, m_sp, m_irq, m_gap;
  bit [1:0] m_mm;

  function automatic bit [31:0] model_vec();
    bit [31:0] v = 0;
    bit [7:0] ta = m_txp & m_txm, ra = m_rxp & m_rxm;
    for (int i = 7; i >= 0; i--) begin
      if (ta[i]) begin v[16] = 1; v[2:0] = 3'(i); end
      if (ra[i]) begin v[17] = 1; v[10:8] = 3'(i); end
    end
    v[18] = m_hp & m_mm[0];
    v[19] = m_sp & m_mm[1];
    return v;
  endfunction

  always @(posedge clk) begin
    bit any_old;
    any_old = |model_vec()[19:16];
    if (!rst_n) begin
      m_txp = 0; m_rxp = 0; m_txm = 0; m_rxm = 0;
      m_hp = 0; m_sp = 0; m_mm = 0; m_irq = 0; m_gap = 0;
    end else begin
      if (we && code == 6) m_txp[data[2:0]] = 0;
      if (we && code == 7) m_rxp[data[2:0]] = 0;
      if (we && code == 8) begin
        if (data[0]) m_hp = 0;
        if (data[1]) m_sp = 0;
      end
      if (tx_done) m_txp[tx_chan] = 1;
      if (rx_done) m_rxp[rx_chan] = 1;
      if (host_err) m_hp = 1;
      if (stat_chg) m_sp = 1;
      if (we) case (code)
        0: m_txm = m_txm | data;
        1: m_txm = m_txm & ~data;
        2: m_rxm = m_rxm | data;
        3: m_rxm = m_rxm & ~data;
        4: m_mm = m_mm | data[1:0];
        5: m_mm = m_mm & ~data[1:0];
        default: ;
      endcase
      if (we && code == 9) m_irq = 0;
      else if (!m_gap && any_old) m_irq = 1;
      m_gap = we && code == 9;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc_n);
    end
  endtask

  always @(negedge clk) begin
    cyc_n++;
    if (cmp_on) begin
      bit [31:0] mv;
      mv = model_vec();
      chk("R2 tx flag", {31'b0, vec[16]}, {31'b0, mv[16]});
      chk("R3 rx flag", {31'b0, vec[17]}, {31'b0, mv[17]});
      chk("R4 channel fields", {vec[10:8], vec[2:0]}, {mv[10:8], mv[2:0]});
      chk("R6 host/status flags", {vec[31:20], vec[19:18]}, {12'b0, mv[19:18]});
      chk("R8/R9 irq line", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic clr_in();
    tx_done = 0; rx_done = 0; host_err = 0; stat_chg = 0; we = 0;
  endtask
  task automatic cmd(input logic [3:0] c, input logic [7:0] d);
    we = 1; code = c; data = d; step(); clr_in();
  endtask
  task automatic ptx(input logic [2:0] ch);
    tx_done = 1; tx_chan = ch; step(); clr_in();
  endtask
  task automatic prx(input logic [2:0] ch);
    rx_done = 1; rx_chan = ch; step(); clr_in();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    chk("R1 vector after reset", vec, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    cmp_on = 1;
    ptx(5);          chk("R2 masked tx not shown", vec, 32'h0);
    cmd(0, 8'hFF);   chk("R2 tx shown after enable", vec, 32'h0001_0005);
    chk("R8 irq one clock late", {31'b0, irq}, 0);
    step();          chk("R8 irq rises", {31'b0, irq}, 1);
    ptx(2);          chk("R4 lowest tx channel", vec, 32'h0001_0002);
    cmd(6, 8'd2);    chk("R7 tx ack", vec, 32'h0001_0005);
    cmd(9, 0);       chk("R9 gap first", {31'b0, irq}, 0);
    step();          chk("R9 gap second", {31'b0, irq}, 0);
    step();          chk("R9 re-assert", {31'b0, irq}, 1);
    cmd(1, 8'h20);   chk("R5 mask clear", vec, 32'h0);
    chk("R8 irq held without flags", {31'b0, irq}, 1);
    cmd(9, 0); step(); step();
    chk("R9 stays low when idle", {31'b0, irq}, 0);
    cmd(2, 8'h88); prx(7); prx(3);
    chk("R3 R4 lowest rx channel", vec, 32'h0002_0300);
    rx_done = 1; rx_chan = 3; we = 1; code = 7; data = 8'd3; step(); clr_in();
    chk("R7 event beats ack", vec, 32'h0002_0300);
    cmd(7, 8'd3);    chk("R7 rx ack", vec, 32'h0002_0700);
    host_err = 1; step(); clr_in();
    chk("R6 host masked", vec, 32'h0002_0700);
    cmd(4, 8'h01);   chk("R6 host enabled", vec, 32'h0006_0700);
    stat_chg = 1; step(); clr_in();
    cmd(4, 8'h02);   chk("R6 status enabled", vec, 32'h000E_0700);
    cmd(8, 8'h01);   chk("R6 host ack", vec, 32'h000A_0700);
    cmd(5, 8'h02);   chk("R6 status masked", vec, 32'h0002_0700);
    cmd(12, 8'hFF); cmd(15, 8'hFF);
    chk("R10 unused codes", vec, 32'h0002_0700);
    cmd(0, 8'h00);   chk("R5 zero data no effect", vec, 32'h0002_0700);
    tx_done = 1; tx_chan = 1; we = 1; code = 9; data = 0; step(); clr_in();
    chk("R9 eoi with event vector", vec, 32'h0003_0701);
    chk("R9 eoi wins", {31'b0, irq}, 0);
    step();          chk("R9 gap with event", {31'b0, irq}, 0);
    step();          chk("R9 rise after gap", {31'b0, irq}, 1);
    for (int n = 0; n < 600; n++) begin
      tx_done = ($urandom % 4) == 0; tx_chan = 3'($urandom);
      rx_done = ($urandom % 4) == 0; rx_chan = 3'($urandom);
      host_err = ($urandom % 16) == 0; stat_chg = ($urandom % 16) == 0;
      we = ($urandom % 2) == 0; code = 4'($urandom % 11); data = 8'($urandom);
      step();
    end
    clr_in(); step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule